// File: doc/BRIEF.md
# I/O Command Processor

This block takes transfer work off a host CPU. The CPU launches a job with a one-cycle start request that carries a start code and a device number. The processor then fetches a two-word transfer descriptor for that device from shared memory. It decodes the descriptor and moves words between the chosen device port and a memory buffer, one word per bus access. Whenever it needs the memory bus it asks for it with a request/grant handshake, so it only uses cycles the CPU gives up. When the job ends it raises an interrupt.

The descriptor for device `d` sits at `DESC_BASE + 8*d`. Word 0 holds the operation in bits [31:28], a flags field in bits [27:16] that has no effect on the transfer, and a word count in bits [15:0]. Word 1 holds the byte address of the buffer. Buffer words are taken at consecutive addresses that step by 4. All device ports share one outgoing data bus. Each port has its own valid/ready pair in each direction.

Top module: `iop_core`

## Requirements
- R1: A start request is accepted only when the processor is idle and `start_op` equals 4'h1. Acceptance raises `start_ack` in that same cycle and `busy` in the next. Any other start code gives no acknowledge, leaves `busy` low and issues no memory request.
- R2: A start request that arrives while `busy` is high is refused. `start_ack` stays low and the running job is not disturbed.
- R3: After acceptance the processor reads descriptor word 0 from `DESC_BASE + 8*dev`, then word 1 from the next word address. Word 0 is {op[31:28], flags[27:16], count[15:0]} and word 1 is the buffer byte address.
- R4: Operation 0 (device to memory) takes `count` words from the selected device in arrival order. It writes them to consecutive word addresses starting at the buffer address.
- R5: Operation 1 (memory to device) reads `count` consecutive words from the buffer and presents them, in order, to the selected device.
- R6: `mem_req` stays high with a stable address and direction until `mem_gnt` is high. Each grant carries exactly one word access. `mem_req` is low in the cycle after every grant.
- R7: When a device holds back valid or ready, the transfer stalls without losing or repeating a word.
- R8: A valid operation with a count of 0 moves no data, finishes and still raises `irq`.
- R9: An operation code other than 0 or 1 moves no data. It sets `stat_err` and raises `irq`.
- R10: `irq` stays high until `irq_clr` is pulsed and then drops. `stat_err` is cleared by the next accepted start.
- R11: Only the selected device ever sees `dev_rx_ready` or `dev_tx_valid` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_valid | input | 1 | Start request from the CPU |
| start_op | input | 4 | Start code (4'h1 launches a job) |
| start_dev | input | SEL_W | Target device number |
| start_ack | output | 1 | Start request accepted |
| busy | output | 1 | A job is in progress |
| irq | output | 1 | Completion interrupt |
| irq_clr | input | 1 | Clears the interrupt |
| stat_err | output | 1 | Last job had an unknown operation |
| mem_req | output | 1 | Memory bus request |
| mem_gnt | input | 1 | Memory bus grant; access occurs this cycle |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid while granted |
| dev_rx_valid | input | N_DEV | Device has a word for the processor |
| dev_rx_data | input | N_DEV*DW | Per-device incoming words |
| dev_rx_ready | output | N_DEV | Processor takes the device word |
| dev_tx_valid | output | N_DEV | Processor offers a word to a device |
| dev_tx_data | output | DW | Shared outgoing word |
| dev_tx_ready | input | N_DEV | Device accepts the offered word |

## Verification
The bench stalls the device ports with periodic valid and ready gaps. A design that latched a word twice or advanced its address during a stall would leave a buffer with repeated or missing entries. Slow grants expose a design that moves its address early, or that holds its request across a grant, because the gap monitor and the written buffer then disagree. Zero counts and unknown operations are checked for stray writes and for a missing interrupt. A second start issued in mid-job must not be acknowledged and must not shorten or lengthen the job. Every device carries distinct data, so a wrong device selection shows up as wrong buffer contents.

// File: rtl/iop_pkg.sv
package iop_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH0,
        ST_FETCH1,
        ST_DECODE,
        ST_DEV_IN,
        ST_MEM_WR,
        ST_MEM_RD,
        ST_DEV_OUT
    } iop_state_e;

    typedef enum logic [1:0] {
        XF_IN,
        XF_OUT,
        XF_NONE,
        XF_BAD
    } xfer_kind_e;

    localparam logic [3:0] START_GO   = 4'h1;
    localparam logic [3:0] OP_DEV2MEM = 4'h0;
    localparam logic [3:0] OP_MEM2DEV = 4'h1;

endpackage

// File: rtl/iop_desc_decode.sv
module iop_desc_decode
    import iop_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic [3:0]       op,
    input  logic [CNT_W-1:0] count,
    output xfer_kind_e       kind
);

    always_comb begin
        if (op == OP_DEV2MEM || op == OP_MEM2DEV) begin
            if (count == '0) begin
                kind = XF_NONE;
            end else if (op == OP_DEV2MEM) begin
                kind = XF_IN;
            end else begin
                kind = XF_OUT;
            end
        end else begin
            kind = XF_BAD;
        end
    end

endmodule

// File: rtl/iop_dev_mux.sv
module iop_dev_mux #(
    parameter int N_DEV = 4,
    parameter int DW    = 32,
    parameter int SEL_W = 2
) (
    input  logic [SEL_W-1:0]    sel,
    input  logic                take_en,
    input  logic                give_en,
    input  logic [N_DEV-1:0]    rx_valid,
    input  logic [N_DEV*DW-1:0] rx_data,
    output logic [N_DEV-1:0]    rx_ready,
    output logic [N_DEV-1:0]    tx_valid,
    input  logic [N_DEV-1:0]    tx_ready,
    output logic                sel_rx_valid,
    output logic [DW-1:0]       sel_rx_data,
    output logic                sel_tx_ready
);

    logic [N_DEV-1:0] hit;

    for (genvar g = 0; g < N_DEV; g++) begin : g_port
        assign hit[g]      = (sel == SEL_W'(g));
        assign rx_ready[g] = take_en & hit[g];
        assign tx_valid[g] = give_en & hit[g];
    end

    always_comb begin
        sel_rx_valid = 1'b0;
        sel_tx_ready = 1'b0;
        sel_rx_data  = '0;
        for (int i = 0; i < N_DEV; i++) begin
            sel_rx_valid = sel_rx_valid | (hit[i] & rx_valid[i]);
            sel_tx_ready = sel_tx_ready | (hit[i] & tx_ready[i]);
            sel_rx_data  = sel_rx_data | (hit[i] ? rx_data[i*DW +: DW] : '0);
        end
    end

endmodule

// File: rtl/iop_core.sv
module iop_core
    import iop_pkg::*;
#(
    parameter int          N_DEV     = 4,
    parameter int          AW        = 32,
    parameter int          DW        = 32,
    parameter int          CNT_W     = 16,
    parameter logic [31:0] DESC_BASE = 32'h0000_0000,
    localparam int         SEL_W     = (N_DEV > 1) ? $clog2(N_DEV) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_valid,
    input  logic [3:0]          start_op,
    input  logic [SEL_W-1:0]    start_dev,
    output logic                start_ack,
    output logic                busy,
    output logic                irq,
    input  logic                irq_clr,
    output logic                stat_err,
    output logic                mem_req,
    input  logic                mem_gnt,
    output logic                mem_we,
    output logic [AW-1:0]       mem_addr,
    output logic [DW-1:0]       mem_wdata,
    input  logic [DW-1:0]       mem_rdata,
    input  logic [N_DEV-1:0]    dev_rx_valid,
    input  logic [N_DEV*DW-1:0] dev_rx_data,
    output logic [N_DEV-1:0]    dev_rx_ready,
    output logic [N_DEV-1:0]    dev_tx_valid,
    output logic [DW-1:0]       dev_tx_data,
    input  logic [N_DEV-1:0]    dev_tx_ready
);

    localparam logic [AW-1:0] WORD_STEP = AW'(4);
    localparam int            DESC_SH   = 3;

    typedef struct packed {
        iop_state_e       st;
        logic [SEL_W-1:0] dev;
        logic [AW-1:0]    addr;
        logic [CNT_W-1:0] cnt;
        logic [DW-1:0]    dbuf;
        logic             gap;
        logic             irq;
        logic             err;
    } regs_t;

    regs_t r_q, r_d;

    logic       take_en, give_en;
    logic       sel_rx_valid, sel_tx_ready;
    logic [DW-1:0] sel_rx_data;
    xfer_kind_e kind;
    logic       granted;

    iop_desc_decode #(.CNT_W(CNT_W)) u_dec (
        .op    (r_q.dbuf[31:28]),
        .count (r_q.dbuf[CNT_W-1:0]),
        .kind  (kind)
    );

    iop_dev_mux #(.N_DEV(N_DEV), .DW(DW), .SEL_W(SEL_W)) u_mux (
        .sel          (r_q.dev),
        .take_en      (take_en),
        .give_en      (give_en),
        .rx_valid     (dev_rx_valid),
        .rx_data      (dev_rx_data),
        .rx_ready     (dev_rx_ready),
        .tx_valid     (dev_tx_valid),
        .tx_ready     (dev_tx_ready),
        .sel_rx_valid (sel_rx_valid),
        .sel_rx_data  (sel_rx_data),
        .sel_tx_ready (sel_tx_ready)
    );

    assign granted = mem_req & mem_gnt;

    always_comb begin
        r_d       = r_q;
        r_d.gap   = 1'b0;
        start_ack = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        take_en   = 1'b0;
        give_en   = 1'b0;

        if (irq_clr) begin
            r_d.irq = 1'b0;
        end

        unique case (r_q.st)
            ST_IDLE: begin
                if (start_valid && start_op == START_GO) begin
                    start_ack = 1'b1;
                    r_d.dev   = start_dev;
                    r_d.err   = 1'b0;
                    r_d.addr  = AW'(DESC_BASE) + (AW'(start_dev) << DESC_SH);
                    r_d.st    = ST_FETCH0;
                end
            end
            ST_FETCH0: begin
                mem_req = ~r_q.gap;
                if (granted) begin
                    r_d.dbuf = mem_rdata;
                    r_d.addr = r_q.addr + WORD_STEP;
                    r_d.gap  = 1'b1;
                    r_d.st   = ST_FETCH1;
                end
            end
            ST_FETCH1: begin
                mem_req = ~r_q.gap;
                if (granted) begin
                    r_d.addr = mem_rdata[AW-1:0];
                    r_d.gap  = 1'b1;
                    r_d.st   = ST_DECODE;
                end
            end
            ST_DECODE: begin
                r_d.cnt = r_q.dbuf[CNT_W-1:0];
                unique case (kind)
                    XF_IN:   r_d.st = ST_DEV_IN;
                    XF_OUT:  r_d.st = ST_MEM_RD;
                    XF_NONE: begin
                        r_d.irq = 1'b1;
                        r_d.st  = ST_IDLE;
                    end
                    default: begin
                        r_d.err = 1'b1;
                        r_d.irq = 1'b1;
                        r_d.st  = ST_IDLE;
                    end
                endcase
            end
            ST_DEV_IN: begin
                take_en = 1'b1;
                if (sel_rx_valid) begin
                    r_d.dbuf = sel_rx_data;
                    r_d.st   = ST_MEM_WR;
                end
            end
            ST_MEM_WR: begin
                mem_req = ~r_q.gap;
                mem_we  = 1'b1;
                if (granted) begin
                    r_d.addr = r_q.addr + WORD_STEP;
                    r_d.cnt  = r_q.cnt - CNT_W'(1);
                    r_d.gap  = 1'b1;
                    if (r_q.cnt == CNT_W'(1)) begin
                        r_d.irq = 1'b1;
                        r_d.st  = ST_IDLE;
                    end else begin
                        r_d.st  = ST_DEV_IN;
                    end
                end
            end
            ST_MEM_RD: begin
                mem_req = ~r_q.gap;
                if (granted) begin
                    r_d.dbuf = mem_rdata;
                    r_d.gap  = 1'b1;
                    r_d.st   = ST_DEV_OUT;
                end
            end
            ST_DEV_OUT: begin
                give_en = 1'b1;
                if (sel_tx_ready) begin
                    r_d.addr = r_q.addr + WORD_STEP;
                    r_d.cnt  = r_q.cnt - CNT_W'(1);
                    if (r_q.cnt == CNT_W'(1)) begin
                        r_d.irq = 1'b1;
                        r_d.st  = ST_IDLE;
                    end else begin
                        r_d.st  = ST_MEM_RD;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy        = (r_q.st != ST_IDLE);
    assign irq         = r_q.irq;
    assign stat_err    = r_q.err;
    assign mem_addr    = r_q.addr;
    assign mem_wdata   = r_q.dbuf;
    assign dev_tx_data = r_q.dbuf;

endmodule

// File: rtl/iop_core_chk.sv
module iop_core_chk #(
    parameter int N_DEV = 4,
    parameter int AW    = 32,
    parameter int DW    = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_ack,
    input logic             busy,
    input logic             irq,
    input logic             irq_clr,
    input logic             mem_req,
    input logic             mem_gnt,
    input logic             mem_we,
    input logic [AW-1:0]    mem_addr,
    input logic [N_DEV-1:0] dev_rx_ready,
    input logic [N_DEV-1:0] dev_tx_valid,
    input logic [N_DEV-1:0] dev_tx_ready,
    input logic [DW-1:0]    dev_tx_data
);

    // R1: an accepted start makes the block busy in the next cycle
    a_r1_ack_busy: assert property (@(posedge clk) disable iff (!rst_n)
        start_ack |=> busy);

    // R2: no acknowledge while a job runs
    a_r2_refuse: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !start_ack);

    // R6: request held until granted
    a_r6_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> mem_req);

    // R6: address and direction stable while waiting
    a_r6_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> ($stable(mem_addr) && $stable(mem_we)));

    // R6: bus released for a cycle after every grant
    a_r6_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_gnt) |=> !mem_req);

    // R7: offered word held until the device takes it
    a_r7_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (|(dev_tx_valid & ~dev_tx_ready)) |=> ($stable(dev_tx_valid) && $stable(dev_tx_data)));

    // R10: interrupt sticks until cleared
    a_r10_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clr) |=> irq);

    // R11: at most one device addressed in each direction
    a_r11_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dev_tx_valid) && $onehot0(dev_rx_ready));

endmodule

bind iop_core iop_core_chk #(.N_DEV(N_DEV), .AW(AW), .DW(DW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_ack    (start_ack),
    .busy         (busy),
    .irq          (irq),
    .irq_clr      (irq_clr),
    .mem_req      (mem_req),
    .mem_gnt      (mem_gnt),
    .mem_we       (mem_we),
    .mem_addr     (mem_addr),
    .dev_rx_ready (dev_rx_ready),
    .dev_tx_valid (dev_tx_valid),
    .dev_tx_ready (dev_tx_ready),
    .dev_tx_data  (dev_tx_data)
);

// File: tb/sim_iop_core.sv
module sim_iop_core;

    localparam int CLK_PERIOD = 10;
    localparam int N_DEV      = 4;
    localparam int DW         = 32;
    localparam int AW         = 32;
    localparam int SEL_W      = 2;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                start_valid = 1'b0;
    logic [3:0]          start_op = 4'h0;
    logic [SEL_W-1:0]    start_dev = '0;
    logic                start_ack, busy, irq, stat_err;
    logic                irq_clr = 1'b0;
    logic                mem_req, mem_we;
    logic                mem_gnt = 1'b0;
    logic [AW-1:0]       mem_addr;
    logic [DW-1:0]       mem_wdata, mem_rdata;
    logic [N_DEV-1:0]    dev_rx_valid, dev_rx_ready, dev_tx_valid, dev_tx_ready;
    logic [N_DEV*DW-1:0] dev_rx_data;
    logic [DW-1:0]       dev_tx_data;

    int errors = 0;
    int checks = 0;

    // bench models
    logic [31:0] mem [256];
    int          gnt_dly = 0;
    int          wait_cnt = 0;
    int          cyc = 0;
    int          wr_cnt = 0;
    int          gap_viol = 0;
    int          bad_dev = 0;
    logic        prev_take = 1'b0;
    int          act_dev = 0;
    logic        src_en = 1'b0, src_stall = 1'b0;
    int          src_idx = 0;
    logic        snk_en = 1'b0, snk_stall = 1'b0;
    logic [31:0] snk [64];
    int          snk_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    iop_core u0 (
        .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_op(start_op),
        .start_dev(start_dev), .start_ack(start_ack), .busy(busy), .irq(irq),
        .irq_clr(irq_clr), .stat_err(stat_err), .mem_req(mem_req), .mem_gnt(mem_gnt),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .dev_rx_valid(dev_rx_valid), .dev_rx_data(dev_rx_data), .dev_rx_ready(dev_rx_ready),
        .dev_tx_valid(dev_tx_valid), .dev_tx_data(dev_tx_data), .dev_tx_ready(dev_tx_ready)
    );

    function automatic logic [31:0] src_word(int d, int i);
        return 32'hA000_0000 + 32'(d * 256) + 32'(i);
    endfunction

    assign mem_rdata    = mem[mem_addr[9:2]];
    assign dev_rx_valid = (src_en && (!src_stall || cyc[0])) ? (4'b0001 << act_dev) : 4'b0000;
    assign dev_tx_ready = (snk_en && (!snk_stall || cyc[1])) ? (4'b0001 << act_dev) : 4'b0000;

    always_comb begin
        for (int d = 0; d < N_DEV; d++) dev_rx_data[d*DW +: DW] = src_word(d, src_idx);
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_req && !mem_gnt) begin
            if (wait_cnt >= gnt_dly) begin
                mem_gnt  <= 1'b1;
                wait_cnt <= 0;
            end else begin
                wait_cnt <= wait_cnt + 1;
            end
        end else begin
            mem_gnt <= 1'b0;
        end
        if (mem_req && mem_gnt && mem_we) begin
            mem[mem_addr[9:2]] <= mem_wdata;
            wr_cnt <= wr_cnt + 1;
        end
        prev_take <= mem_req && mem_gnt;
        if (prev_take && mem_req) gap_viol <= gap_viol + 1;
        if (|(dev_rx_valid & dev_rx_ready)) src_idx <= src_idx + 1;
        if (|(dev_tx_valid & dev_tx_ready)) begin
            snk[snk_cnt[5:0]] <= dev_tx_data;
            snk_cnt <= snk_cnt + 1;
        end
        if (|((dev_tx_valid | dev_rx_ready) & ~(4'b0001 << act_dev))) bad_dev <= bad_dev + 1;
    end

    task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_desc(int dev, logic [3:0] op, int count, logic [31:0] addr);
        mem[dev*2]     = {op, 12'h5A5, 16'(count)};
        mem[dev*2 + 1] = addr;
    endtask

    task automatic do_start(logic [3:0] op, int dev, output logic ack);
        @(negedge clk);
        start_valid = 1'b1;
        start_op    = op;
        start_dev   = SEL_W'(dev);
        #1 ack = start_ack;
        @(negedge clk);
        start_valid = 1'b0;
    endtask

    task automatic wait_irq();
        int n = 0;
        while (!irq && n < 3000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic clear_irq();
        @(negedge clk);
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
    endtask

    task automatic t_reset();
        check(busy == 0 && irq == 0 && mem_req == 0 && stat_err == 0, "R1 reset state",
              {28'h0, busy, irq, mem_req, stat_err}, 32'h0);
    endtask

    task automatic t_read_basic();
        logic ack;
        int s0 = src_idx, w0 = wr_cnt;
        act_dev = 1; src_en = 1; src_stall = 0; gnt_dly = 0;
        set_desc(1, 4'h0, 4, 32'h100);
        do_start(4'h1, 1, ack);
        check(ack == 1'b1, "R1 ack on idle start", 32'(ack), 32'h1);
        check(busy == 1'b1, "R1 busy after accept", 32'(busy), 32'h1);
        wait_irq();
        for (int i = 0; i < 4; i++)
            check(mem[64+i] == src_word(1, s0+i), "R3 R4 read word", mem[64+i], src_word(1, s0+i));
        check(wr_cnt - w0 == 4, "R4 write count", 32'(wr_cnt - w0), 32'd4);
        check(irq == 1 && busy == 0 && stat_err == 0, "R4 completion",
              {29'h0, irq, busy, stat_err}, 32'h4);
        repeat (5) @(negedge clk);
        check(irq == 1'b1, "R10 irq sticky", 32'(irq), 32'h1);
        clear_irq();
        check(irq == 1'b0, "R10 irq cleared", 32'(irq), 32'h0);
        src_en = 0;
    endtask

    task automatic t_write_stall();
        logic ack;
        int k0 = snk_cnt;
        act_dev = 2; snk_en = 1; snk_stall = 1; gnt_dly = 3;
        for (int i = 0; i < 3; i++) mem[128+i] = 32'hC0DE_0000 + 32'(i * 7);
        set_desc(2, 4'h1, 3, 32'h200);
        do_start(4'h1, 2, ack);
        wait_irq();
        check(snk_cnt - k0 == 3, "R5 words delivered", 32'(snk_cnt - k0), 32'd3);
        for (int i = 0; i < 3; i++)
            check(snk[k0+i] == 32'hC0DE_0000 + 32'(i*7), "R5 R7 device word order",
                  snk[k0+i], 32'hC0DE_0000 + 32'(i*7));
        check(gap_viol == 0, "R6 bus released after grant", 32'(gap_viol), 32'h0);
        clear_irq();
        snk_en = 0; snk_stall = 0;
    endtask

    task automatic t_read_stall();
        logic ack;
        int s0 = src_idx, w0 = wr_cnt;
        act_dev = 0; src_en = 1; src_stall = 1; gnt_dly = 2;
        set_desc(0, 4'h0, 5, 32'h180);
        do_start(4'h1, 0, ack);
        wait_irq();
        for (int i = 0; i < 5; i++)
            check(mem[96+i] == src_word(0, s0+i), "R7 stalled read word", mem[96+i], src_word(0, s0+i));
        check(wr_cnt - w0 == 5 && src_idx - s0 == 5, "R7 no loss or repeat",
              32'(src_idx - s0), 32'd5);
        clear_irq();
        src_en = 0; src_stall = 0;
    endtask

    task automatic t_busy_refuse();
        logic ack;
        int w0 = wr_cnt;
        act_dev = 3; src_en = 1; src_stall = 1; gnt_dly = 1;
        set_desc(3, 4'h0, 6, 32'h280);
        do_start(4'h1, 3, ack);
        do_start(4'h1, 3, ack);
        check(ack == 1'b0, "R2 refused while busy", 32'(ack), 32'h0);
        check(busy == 1'b1, "R2 busy reported", 32'(busy), 32'h1);
        wait_irq();
        check(wr_cnt - w0 == 6, "R2 job unaffected", 32'(wr_cnt - w0), 32'd6);
        clear_irq();
        src_en = 0; src_stall = 0;
    endtask

    task automatic t_zero_count();
        logic ack;
        int w0 = wr_cnt;
        act_dev = 0; gnt_dly = 0;
        mem[192] = 32'hDEAD_BEEF;
        set_desc(0, 4'h0, 0, 32'h300);
        do_start(4'h1, 0, ack);
        wait_irq();
        check(irq == 1'b1 && stat_err == 1'b0, "R8 zero count completes",
              {30'h0, irq, stat_err}, 32'h2);
        check(wr_cnt == w0 && mem[192] == 32'hDEAD_BEEF, "R8 no data moved", mem[192], 32'hDEAD_BEEF);
        clear_irq();
    endtask

    task automatic t_bad_op();
        logic ack;
        int w0 = wr_cnt, s0 = src_idx;
        act_dev = 1; src_en = 1;
        set_desc(1, 4'h7, 2, 32'h100);
        do_start(4'h1, 1, ack);
        wait_irq();
        check(stat_err == 1'b1 && irq == 1'b1, "R9 error and irq", {30'h0, stat_err, irq}, 32'h3);
        check(wr_cnt == w0 && src_idx == s0, "R9 no transfer", 32'(wr_cnt - w0), 32'h0);
        clear_irq();
        check(stat_err == 1'b1, "R10 error kept after irq clear", 32'(stat_err), 32'h1);
        src_en = 0;
        act_dev = 0;
        set_desc(0, 4'h0, 0, 32'h300);
        do_start(4'h1, 0, ack);
        wait_irq();
        check(stat_err == 1'b0, "R10 error cleared by next start", 32'(stat_err), 32'h0);
        clear_irq();
    endtask

    task automatic t_bad_code();
        logic ack;
        do_start(4'h3, 2, ack);
        check(ack == 1'b0, "R1 wrong start code ignored", 32'(ack), 32'h0);
        check(busy == 1'b0 && mem_req == 1'b0, "R1 stays idle", {30'h0, busy, mem_req}, 32'h0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 32'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_read_basic();
        t_write_stall();
        t_read_stall();
        t_busy_refuse();
        t_zero_count();
        t_bad_op();
        t_bad_code();
        check(bad_dev == 0, "R11 only selected device addressed", 32'(bad_dev), 32'h0);
        check(gap_viol == 0, "R6 release after every grant", 32'(gap_viol), 32'h0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule